// File: doc/BRIEF.md
# Program trace byte-stream decoder

This block sits behind a processor trace port and turns the raw byte stream into the sequence of instruction addresses the program actually ran. Every byte is thrown away until the decoder sees the alignment pattern. After that it reads packets: one full start address, branch packets that carry compressed jump targets, and timestamp packets, which it skips. Each complete address goes out on a valid/ready stream. A flag reports that the stream was judged corrupt and that the decoder is hunting for alignment again.

The decoder takes one byte per clock. When a finished address is still waiting for the consumer, it stops accepting bytes until the consumer takes that address. Selective tracing leaves gaps in the stream, and those gaps are normal: filler bytes between packets are skipped silently.

Top module: `trace_flow_decoder`

## Requirements
- R1: After reset, addr_valid and sync_lost are 0 and in_ready is 1.
- R2: Before alignment is found, no byte produces an address, including bytes that would form a valid packet.
- R3: Alignment is found on a byte 0x80 that follows at least SYNC_ZEROS (default 4) consecutive 0x00 bytes. A 0x80 after fewer zeros does not align the decoder.
- R4: Once aligned, header 0x02 followed by four bytes, least significant byte first, emits that 32-bit start address.
- R5: A header byte with bit 0 set starts a branch packet. Bit 7 of every byte in the packet means another byte follows. Byte 0 bits 6:1 give address bits 5:0, byte 1 bits 6:0 give bits 12:6, byte 2 gives bits 19:13, byte 3 gives bits 26:20, and byte 4 bits 4:0 give bits 31:27. The last byte completes the packet and emits the address.
- R6: Any address bits that a shorter branch packet does not carry are copied from the most recently emitted address. A repeated one-byte packet therefore yields one address per packet.
- R7: Header 0x04 starts a timestamp. The decoder skips the following bytes up to and including the first one with bit 7 clear, emits nothing for them, and reads the next byte as a header.
- R8: Once aligned, the bytes 0x00 and 0x80 in header position are ignored. They change neither the alignment nor the stored previous address.
- R9: Once aligned, a header byte with bit 0 clear other than 0x00, 0x80, 0x02 or 0x04 sets sync_lost. Bytes are then discarded until the next alignment pattern, which clears sync_lost.
- R10: A branch packet whose fifth byte has bit 7 set sets sync_lost, as does a timestamp whose TS_MAX-th payload byte (default 8) still has bit 7 set. A timestamp of exactly TS_MAX payload bytes that ends correctly is accepted.
- R11: While addr_valid is 1 and addr_ready is 0, addr_out and addr_valid hold and in_ready is 0. When addr_ready is 1, each address shows for exactly one cycle.
- R12: Each alignment resets the stored previous address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A trace byte is present |
| in_data | input | 8 | Trace byte |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| addr_valid | output | 1 | Decoded address available |
| addr_out | output | 32 | Decoded instruction address |
| addr_ready | input | 1 | Consumer takes the address |
| sync_lost | output | 1 | Stream judged corrupt; awaiting alignment |

## Verification
The assertions assume that the consumer treats a valid address as a handshake, so addr_out has to hold only while addr_ready is low. They also assume that in_data is read only when in_valid and in_ready are both high. The stimulus meets both assumptions: it changes in_data only after in_ready has been seen high at the preceding edge, and it holds the consumer ready except in the single test that applies backpressure. Every byte sequence the bench sends is built from the packet layouts stated in the requirements. The malformed packets are built on purpose to reach the two error paths.

// File: rtl/trace_flow_decoder.sv
module trace_flow_decoder #(
  parameter int SYNC_ZEROS = 4,
  parameter int TS_MAX     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        addr_valid,
  output logic [31:0] addr_out,
  input  logic        addr_ready,
  output logic        sync_lost
);

  localparam int ZC_W = $clog2(SYNC_ZEROS + 1);
  localparam int IX_W = $clog2((TS_MAX > 5 ? TS_MAX : 5) + 1);
  localparam logic [ZC_W-1:0] ZMAX = ZC_W'(SYNC_ZEROS);
  localparam logic [IX_W-1:0] TLAST = IX_W'(TS_MAX - 1);

  typedef enum logic [2:0] {HUNT, HEAD, BRANCH, START, TSKIP} st_t;

  st_t              st, nst;
  logic [ZC_W-1:0]  zcnt, nzcnt;
  logic [IX_W-1:0]  idx, nidx;
  logic [31:0]      work, nwork, prev;
  logic             done, err, aligned;

  wire       take = in_valid && in_ready;
  wire [7:0] b    = in_data;

  assign in_ready = !addr_valid || addr_ready;

  always_comb begin
    nst = st; nidx = idx; nwork = work; nzcnt = zcnt;
    done = 1'b0; err = 1'b0; aligned = 1'b0;
    case (st)
      HUNT: begin
        if (b == 8'h00) nzcnt = (zcnt == ZMAX) ? zcnt : zcnt + 1'b1;
        else if (b == 8'h80 && zcnt == ZMAX) begin
          aligned = 1'b1; nst = HEAD; nzcnt = '0;
        end else nzcnt = '0;
      end
      HEAD: begin
        if (b[0]) begin
          nwork = {prev[31:6], b[6:1]};
          if (b[7]) begin nst = BRANCH; nidx = IX_W'(1); end
          else done = 1'b1;
        end else begin
          case (b)
            8'h00, 8'h80: ;
            8'h02: begin nst = START; nidx = '0; end
            8'h04: begin nst = TSKIP; nidx = '0; end
            default: err = 1'b1;
          endcase
        end
      end
      BRANCH: begin
        case (idx)
          IX_W'(1): nwork[12:6]  = b[6:0];
          IX_W'(2): nwork[19:13] = b[6:0];
          IX_W'(3): nwork[26:20] = b[6:0];
          default:  nwork[31:27] = b[4:0];
        endcase
        if (!b[7]) begin done = 1'b1; nst = HEAD; end
        else if (idx == IX_W'(4)) err = 1'b1;
        else nidx = idx + 1'b1;
      end
      START: begin
        case (idx)
          IX_W'(0): nwork[7:0]   = b;
          IX_W'(1): nwork[15:8]  = b;
          IX_W'(2): nwork[23:16] = b;
          default:  nwork[31:24] = b;
        endcase
        if (idx == IX_W'(3)) begin done = 1'b1; nst = HEAD; end
        else nidx = idx + 1'b1;
      end
      TSKIP: begin
        if (!b[7]) nst = HEAD;
        else if (idx == TLAST) err = 1'b1;
        else nidx = idx + 1'b1;
      end
      default: nst = HUNT;
    endcase
    if (err) begin nst = HUNT; nzcnt = '0; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT; zcnt <= '0; idx <= '0; work <= '0; prev <= '0;
      addr_valid <= 1'b0; addr_out <= '0; sync_lost <= 1'b0;
    end else begin
      if (take) begin
        st <= nst; zcnt <= nzcnt; idx <= nidx; work <= nwork;
        if (done) begin prev <= nwork; addr_out <= nwork; end
        if (err) sync_lost <= 1'b1;
        if (aligned) begin sync_lost <= 1'b0; prev <= '0; end
      end
      if (take && done) addr_valid <= 1'b1;
      else if (addr_ready) addr_valid <= 1'b0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_out));
  p_lost_hunts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> st == HUNT);
  p_resync_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_lost) |-> st == HEAD);
  p_no_out_unsynced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> $past(st) != HUNT);
  p_branch_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == BRANCH |-> idx >= IX_W'(1) && idx <= IX_W'(4));
  p_ts_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == TSKIP |-> idx <= TLAST);

endmodule

// File: tb/trace_flow_decoder_tb_top.sv
module trace_flow_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, addr_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, addr_valid, sync_lost;
  logic [31:0] addr_out;
  int total = 0, bad = 0, cyc = 0;
  logic [31:0] got[$];

  always #2.5 clk = ~clk;

  trace_flow_decoder dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .addr_valid(addr_valid),
    .addr_out(addr_out), .addr_ready(addr_ready), .sync_lost(sync_lost));

  always @(negedge clk) if (rst_n && addr_valid && addr_ready) got.push_back(addr_out);

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s: act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic sendb(input logic [7:0] b);
    @(posedge clk); #1; in_valid = 1'b1; in_data = b;
    @(negedge clk); while (!in_ready) @(negedge clk);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1; in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_addr(input string tag, input logic [31:0] exp);
    if (got.size() == 0) chk({tag, " missing"}, 32'hDEAD_0000, exp);
    else chk(tag, got.pop_front(), exp);
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " extra addresses"}, got.size(), 0);
    got.delete();
  endtask

  task automatic do_sync();
    repeat (4) sendb(8'h00);
    sendb(8'h80);
  endtask

  task automatic send_start(input logic [31:0] a);
    sendb(8'h02); sendb(a[7:0]); sendb(a[15:8]); sendb(a[23:16]); sendb(a[31:24]);
  endtask

  task automatic send_branch(input logic [31:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      logic c; c = (k < n - 1);
      case (k)
        0: sendb({c, a[5:0], 1'b1});
        1: sendb({c, a[12:6]});
        2: sendb({c, a[19:13]});
        3: sendb({c, a[26:20]});
        default: sendb({c, 2'b00, a[31:27]});
      endcase
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] p, input logic [31:0] t, input int n);
    logic [31:0] m;
    case (n) 1: m = 32'h3F; 2: m = 32'h1FFF; 3: m = 32'hF_FFFF; 4: m = 32'h7FF_FFFF; default: m = '1; endcase
    return (p & ~m) | (t & m);
  endfunction

  task automatic t_reset();
    chk("R1 addr_valid", addr_valid, 0);
    chk("R1 sync_lost", sync_lost, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_presync();
    send_start(32'h1122_3344); send_branch(32'h55, 1); sendb(8'h04); sendb(8'h01);
    idle(4); expect_none("R2 before alignment");
  endtask

  task automatic t_sync_start();
    repeat (3) sendb(8'h00); sendb(8'h80); send_start(32'hCAFE_0001);
    idle(4); expect_none("R3 three zeros do not align");
    do_sync(); send_start(32'h1234_5678); idle(4);
    expect_addr("R4 start address", 32'h1234_5678); expect_none("R4");
  endtask

  task automatic t_branch_compress();
    logic [31:0] p, t;
    p = 32'h1234_5678;
    t = 32'hA5C3_9E64; send_branch(t, 5); idle(3);
    expect_addr("R5 full branch", t); p = t;
    t = 32'h0000_002B; send_branch(t, 1); idle(3);
    expect_addr("R6 one-byte branch", merge(p, t, 1)); p = merge(p, t, 1);
    t = 32'h0000_1F40; send_branch(t, 2); idle(3);
    expect_addr("R6 two-byte branch", merge(p, t, 2)); p = merge(p, t, 2);
    t = 32'h0007_0ABC; send_branch(t, 3); idle(3);
    expect_addr("R6 three-byte branch", merge(p, t, 3)); p = merge(p, t, 3);
    t = 32'h0123_4567; send_branch(t, 4); idle(3);
    expect_addr("R6 four-byte branch", merge(p, t, 4)); p = merge(p, t, 4);
    t = 32'h0000_0010;
    for (int i = 0; i < 10; i++) send_branch(t, 1);
    idle(3);
    chk("R6 loop count", got.size(), 10);
    for (int i = 0; i < 10; i++) expect_addr("R6 loop address", merge(p, t, 1));
    p = merge(p, t, 1);
    sendb(8'h04); sendb(8'h85); sendb(8'h81); sendb(8'h03);
    t = 32'h0000_0021; send_branch(t, 1); idle(3);
    expect_addr("R7 branch after timestamp", merge(p, t, 1)); expect_none("R7");
    p = merge(p, t, 1);
    repeat (4) sendb(8'h00); sendb(8'h80); sendb(8'h00);
    t = 32'h0000_0007; send_branch(t, 1); idle(3);
    expect_addr("R8 previous kept across filler", merge(p, t, 1)); expect_none("R8");
    chk("R8 sync_lost", sync_lost, 0);
  endtask

  task automatic t_bad_header();
    sendb(8'h06); idle(1);
    chk("R9 sync_lost set", sync_lost, 1);
    send_start(32'h7777_8888); send_branch(32'h3, 1); idle(3);
    expect_none("R9 discard after loss");
    chk("R9 sync_lost held", sync_lost, 1);
    do_sync(); idle(1);
    chk("R9 sync_lost cleared", sync_lost, 0);
    send_branch(32'h15, 1); idle(3);
    expect_addr("R12 previous reset by alignment", 32'h0000_0015);
  endtask

  task automatic t_overlong();
    repeat (5) sendb(8'h81); idle(2);
    chk("R10 overlong branch", sync_lost, 1); expect_none("R10 overlong branch");
    do_sync(); send_start(32'h4000_0000);
    sendb(8'h04); repeat (7) sendb(8'h80); sendb(8'h01);
    send_branch(32'h3F, 1); idle(3);
    chk("R10 max timestamp ok", sync_lost, 0);
    expect_addr("R10 start", 32'h4000_0000);
    expect_addr("R10 branch after max timestamp", 32'h4000_003F);
    sendb(8'h04); repeat (8) sendb(8'h80); idle(2);
    chk("R10 overlong timestamp", sync_lost, 1);
  endtask

  task automatic t_backpressure();
    do_sync();
    @(posedge clk); #1; addr_ready = 1'b0;
    send_start(32'h8000_1000);
    @(posedge clk); #1; in_valid = 1'b1; in_data = {1'b0, 6'h05, 1'b1};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 in_ready low", in_ready, 0);
      chk("R11 valid held", addr_valid, 1);
      chk("R11 addr held", addr_out, 32'h8000_1000);
    end
    @(posedge clk); #1; addr_ready = 1'b1;
    idle(3);
    expect_addr("R11 first after stall", 32'h8000_1000);
    expect_addr("R11 second after stall", 32'h8000_1005);
    expect_none("R11 single pulse");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_presync();
    t_sync_start();
    t_branch_compress();
    t_bad_header();
    t_overlong();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule